// File: doc/BRIEF.md
# Single-to-Brain-Float Rounding Converter

This block narrows a 32-bit IEEE-754 single-precision word into a 16-bit brain-float word (sign, 8-bit exponent, 7-bit fraction). A new input is offered with a one-cycle strobe. The narrowed result appears on a registered output, together with its own strobe, on the next clock.

Ordinary values, infinities included, are rounded to nearest with ties going to the even result. The rounding needs only one integer addition: a bias of 0x7FFF, plus the least significant kept bit, is added to the word and the upper half is taken. The carry out of the 32-bit sum is dropped. A NaN input keeps its upper half, and the most significant fraction bit of that half is forced to one so that the result is a quiet NaN.

A second, purely combinational path widens a brain-float word back to single precision by padding it with zero bits. Benches use it to build reference values.

Top module: `fbr_fp32_to_bf16`

## Requirements
- R1: `out_vld` equals the value `in_vld` had on the previous rising clock edge. While `rst_n` is low at a rising edge, `out_vld` and `out_half` are cleared to 0.
- R2: For an input whose bits 30:0 are at most 0x7F800000, `out_half` is bits 31:16 of the 32-bit sum (input + 0x7FFF + input bit 16), with the carry out discarded.
- R3: Ties round to even. With bits 15:0 equal to 0x8000, the upper half is kept as is when bit 16 is 0, and it is incremented when bit 16 is 1.
- R4: An input whose bits 30:0 are strictly greater than 0x7F800000 is a NaN. For it, `out_half` is input bits 31:16 ORed with 0x0040 (bit 6 is the quiet bit). So 0x7F800001 gives 0x7FC0, and 0xFFC12345 gives 0xFFC1.
- R5: Positive infinity 0x7F800000 gives 0x7F80, and negative infinity 0xFF800000 gives 0xFF80.
- R6: A finite input close to the largest magnitude may round up into the infinity code. 0x7F7FFFFF gives 0x7F80, and 0xFF7F8000 gives 0xFF80.
- R7: On a cycle with `in_vld` low, `out_half` keeps its value, whatever `in_word` holds.
- R8: `wide_out` equals `wide_in` in bits 31:16, with bits 15:0 zero, in the same cycle.
- R9: Known values: 0x41000000 (8.0) gives 0x4100, and 0xC0800000 (-4.0) gives 0xC080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision input word |
| out_vld | output | 1 | Registered result valid |
| out_half | output | 16 | Registered brain-float result |
| wide_in | input | 16 | Brain-float word to widen |
| wide_out | output | 32 | Widened single-precision word |

## Verification
The checker watches, on every cycle, the one-cycle valid timing, that the result holds on idle cycles, the NaN quieting, the mapping of infinities and the zero fill of the widening path. The exact rounding result for ordinary values is shown only by the bench's scenarios. These cover directed ties to odd and even, the overflow into infinity and the known constants, and 10,000 random words are compared against a model of the add-and-truncate formula. Reset clearing is also a bench-only scenario, because the checker is disabled while reset is held.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   localparam int unsigned SGL_W   = 32;
   localparam int unsigned BRF_W   = 16;
   localparam int unsigned EXPO_W  = 8;
endpackage

// File: rtl/fbr_nan_detect.sv
module fbr_nan_detect #(
   parameter int unsigned W_IN  = 32,
   parameter int unsigned EXP_W = 8
) (
   input  logic [W_IN-1:0] word_i,
   output logic            is_nan_o
);
   localparam int unsigned MAG_W  = W_IN - 1;
   localparam int unsigned FRAC_W = MAG_W - EXP_W;
   localparam logic [MAG_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

   logic [MAG_W-1:0] mag;

   assign mag      = word_i[MAG_W-1:0];
   assign is_nan_o = (mag > INF_MAG);
endmodule

// File: rtl/fbr_rne_round.sv
module fbr_rne_round #(
   parameter int unsigned W_IN  = 32,
   parameter int unsigned W_OUT = 16
) (
   input  logic [W_IN-1:0]  word_i,
   output logic [W_OUT-1:0] half_o
);
   localparam int unsigned DROP_W = W_IN - W_OUT;
   // The dropped low half plus the kept LSB must exceed this value to
   // carry into the kept half when the bias (half-scale minus one) is added.
   localparam logic [DROP_W:0] HALF_SCALE = {2'b01, {(DROP_W-1){1'b0}}};

   logic [W_OUT-1:0]  hi;
   logic [DROP_W-1:0] lo;
   logic              keep_lsb;
   logic [DROP_W:0]   lo_plus;
   logic              carry;

   assign hi       = word_i[W_IN-1:DROP_W];
   assign lo       = word_i[DROP_W-1:0];
   assign keep_lsb = word_i[DROP_W];
   assign lo_plus  = {1'b0, lo} + {{DROP_W{1'b0}}, keep_lsb};
   assign carry    = (lo_plus > HALF_SCALE);
   // Wraps at W_OUT bits: the carry out of the full sum is discarded.
   assign half_o   = hi + {{(W_OUT-1){1'b0}}, carry};
endmodule

// File: rtl/fbr_widen.sv
module fbr_widen #(
   parameter int unsigned W_IN  = 32,
   parameter int unsigned W_OUT = 16
) (
   input  logic [W_OUT-1:0] half_i,
   output logic [W_IN-1:0]  word_o
);
   localparam int unsigned PAD_W = W_IN - W_OUT;

   generate
      if (PAD_W > 0) begin : g_pad
         assign word_o = {half_i, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign word_o = half_i;
      end
   endgenerate
endmodule

// File: rtl/fbr_fp32_to_bf16.sv
module fbr_fp32_to_bf16 #(
   parameter int unsigned W_IN  = fbr_pkg::SGL_W,
   parameter int unsigned W_OUT = fbr_pkg::BRF_W,
   parameter int unsigned EXP_W = fbr_pkg::EXPO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [31:0]      in_word,
   output logic             out_vld,
   output logic [15:0]      out_half,
   input  logic [15:0]      wide_in,
   output logic [31:0]      wide_out
);
   localparam int unsigned DROP_W    = W_IN - W_OUT;
   localparam int unsigned QUIET_IDX = W_OUT - EXP_W - 2;
   localparam logic [W_OUT-1:0] QUIET_MASK = {{(W_OUT-1){1'b0}}, 1'b1} << QUIET_IDX;

   generate
      if (W_IN != 32 || W_OUT != 16) begin : g_bad_width
         $error("fbr_fp32_to_bf16: ports are fixed at 32 in and 16 out");
      end
      if (EXP_W + 2 > W_OUT) begin : g_bad_exp
         $error("fbr_fp32_to_bf16: exponent leaves no fraction in output");
      end
      if (DROP_W < 2) begin : g_bad_drop
         $error("fbr_fp32_to_bf16: need at least two dropped bits");
      end
   endgenerate

   logic             nan_hit;
   logic [W_OUT-1:0] rounded;
   logic [W_OUT-1:0] quieted;
   logic [W_OUT-1:0] next_half;

   fbr_nan_detect #(.W_IN(W_IN), .EXP_W(EXP_W)) nan_i (
      .word_i   (in_word),
      .is_nan_o (nan_hit)
   );

   fbr_rne_round #(.W_IN(W_IN), .W_OUT(W_OUT)) rnd_i (
      .word_i (in_word),
      .half_o (rounded)
   );

   fbr_widen #(.W_IN(W_IN), .W_OUT(W_OUT)) wid_i (
      .half_i (wide_in),
      .word_o (wide_out)
   );

   assign quieted   = in_word[W_IN-1:DROP_W] | QUIET_MASK;
   assign next_half = nan_hit ? quieted : rounded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_half <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_half <= next_half;
         end
      end
   end
endmodule

// File: rtl/fbr_chk.sv
module fbr_chk #(
   parameter int unsigned W_IN  = 32,
   parameter int unsigned W_OUT = 16,
   parameter int unsigned EXP_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic [W_IN-1:0]  in_word,
   input logic             out_vld,
   input logic [W_OUT-1:0] out_half,
   input logic [W_OUT-1:0] wide_in,
   input logic [W_IN-1:0]  wide_out
);
   localparam int unsigned DROP_W = W_IN - W_OUT;
   localparam int unsigned FRAC_W = W_OUT - 1 - EXP_W;
   localparam logic [W_IN-2:0] INF_MAG = {{EXP_W{1'b1}}, {(W_IN-1-EXP_W){1'b0}}};
   localparam logic [W_OUT-2:0] INF_HALF = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

   logic in_nan;
   logic in_inf;
   assign in_nan = (in_word[W_IN-2:0] > INF_MAG);
   assign in_inf = (in_word[W_IN-2:0] == INF_MAG);

   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R1
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R4
   nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_nan) |=>
         (out_half[W_OUT-2 -: EXP_W] == {EXP_W{1'b1}}) && out_half[FRAC_W-1]
         && (out_half[W_OUT-1] == $past(in_word[W_IN-1]))
         && (out_half[FRAC_W-2:0] == $past(in_word[DROP_W+FRAC_W-2:DROP_W])));
   // R5
   inf_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_inf) |=> (out_half == {$past(in_word[W_IN-1]), INF_HALF}));
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_half));
   // R8
   widen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_out[DROP_W-1:0] == '0) && (wide_out[W_IN-1:DROP_W] == wide_in));
endmodule

bind fbr_fp32_to_bf16 fbr_chk #(.W_IN(W_IN), .W_OUT(W_OUT), .EXP_W(EXP_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_word  (in_word),
   .out_vld  (out_vld),
   .out_half (out_half),
   .wide_in  (wide_in),
   .wide_out (wide_out)
);

// File: tb/fbr_fp32_to_bf16_tb_top.sv
`timescale 1ns/1ps
module fbr_fp32_to_bf16_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_vld;
   logic [15:0] out_half;
   logic [15:0] wide_in = '0;
   logic [31:0] wide_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fbr_fp32_to_bf16 dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
      .out_vld(out_vld), .out_half(out_half),
      .wide_in(wide_in), .wide_out(wide_out)
   );

   function automatic logic [15:0] model(input logic [31:0] x);
      logic [31:0] s;
      if ((x & 32'h7FFF_FFFF) > 32'h7F80_0000) return x[31:16] | 16'h0040;
      s = x + 32'h0000_7FFF + {31'b0, x[16]};
      return s[31:16];
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one word for one cycle; the result is sampled one cycle later.
   task automatic push(input string req, input logic [31:0] x,
                       input logic [15:0] exp);
      @(negedge clk);
      in_vld  = 1'b1;
      in_word = x;
      @(negedge clk);
      in_vld  = 1'b0;
      check({req, " vld"}, {31'b0, out_vld}, 32'd1);
      check(req, {16'b0, out_half}, {16'b0, exp});
   endtask

   task automatic t_reset();
      check("R1 reset vld", {31'b0, out_vld}, 32'd0);
      check("R1 reset data", {16'b0, out_half}, 32'd0);
   endtask

   task automatic t_known();
      push("R9 8.0", 32'h4100_0000, 16'h4100);
      push("R9 -4.0", 32'hC080_0000, 16'hC080);
      push("R2 rounds up", 32'h3F80_C000, 16'h3F81);
      push("R2 rounds down", 32'h3F80_7FFF, 16'h3F80);
   endtask

   task automatic t_ties();
      push("R3 tie even keep", 32'h3F80_8000, 16'h3F80);
      push("R3 tie odd up", 32'h3F81_8000, 16'h3F82);
      push("R3 tie carry", 32'h3FFF_8000, 16'h4000);
      for (int i = 0; i < 50; i++) begin
         logic [31:0] x;
         x = {$urandom_range(16'h7F7F, 0), 16'h8000};
         x[31] = i[0];
         push("R3 random tie", x, model(x));
      end
   endtask

   task automatic t_nan();
      push("R4 low payload", 32'h7F80_0001, 16'h7FC0);
      push("R4 neg payload", 32'hFFC1_2345, 16'hFFC1);
      push("R4 quiet kept", 32'h7FC0_0000, 16'h7FC0);
      push("R4 all ones", 32'hFFFF_FFFF, 16'hFFFF);
   endtask

   task automatic t_inf();
      push("R5 +inf", 32'h7F80_0000, 16'h7F80);
      push("R5 -inf", 32'hFF80_0000, 16'hFF80);
   endtask

   task automatic t_overflow();
      push("R6 max pos", 32'h7F7F_FFFF, 16'h7F80);
      push("R6 neg tie", 32'hFF7F_8000, 16'hFF80);
   endtask

   task automatic t_hold();
      push("R7 setup", 32'h4049_0FDB, 16'h4049);
      in_word = 32'hC2C8_0000;
      @(negedge clk);
      check("R7 idle vld", {31'b0, out_vld}, 32'd0);
      check("R7 held", {16'b0, out_half}, 32'h0000_4049);
      in_word = 32'h7FC0_0000;
      @(negedge clk);
      check("R7 held again", {16'b0, out_half}, 32'h0000_4049);
   endtask

   task automatic t_widen();
      logic [15:0] v [4] = '{16'h0000, 16'h4100, 16'hFF80, 16'h7FC1};
      foreach (v[i]) begin
         wide_in = v[i];
         #1;
         check("R8 widen", wide_out, {v[i], 16'h0000});
      end
   endtask

   task automatic t_midreset();
      @(negedge clk);
      in_vld  = 1'b1;
      in_word = 32'h4100_0000;
      rst_n   = 1'b0;
      @(negedge clk);
      check("R1 reset overrides vld", {31'b0, out_vld}, 32'd0);
      check("R1 reset clears data", {16'b0, out_half}, 32'd0);
      in_vld = 1'b0;
      rst_n  = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_random();
      for (int i = 0; i < 10000; i++) begin
         logic [31:0] x;
         x = $urandom();
         push("R2 random", x, model(x));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_known();
      t_ties();
      t_nan();
      t_inf();
      t_overflow();
      t_hold();
      t_widen();
      t_midreset();
      t_random();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule